// File: doc/BRIEF.md
# Quarter-Rate Quadrature Sign Mixer

This block converts a stream of real sampled data into complex baseband in-phase and quadrature streams, for a receiver whose intermediate frequency is placed at an odd multiple of one quarter of the sample rate. With that placement the wanted channel always aliases to exactly fs/4. At fs/4 the cosine and sine of the mixing oscillator take only the values +1, 0 and -1. The block therefore needs neither a multiplier nor a phase accumulator with a sine table: every accepted sample is passed through, negated or replaced by zero, according to a two-bit phase count. The result is steered to the I or the Q lane.

The sample rate is fixed and shared by every radio mode that uses the block, so the sign pattern never changes rate. A qualifier marks the input cycles that carry a sample, and the phase advances only on those cycles. A static control input negates the Q lane. This flips the spectral orientation and covers the aliasing zones where the image folds the other way. Both lanes leave the block through registers, one cycle after the sample enters. A lane emits zeros on the phases where its weight is zero. The channel filters and decimators that follow are not part of this block.

Top module: `qrt_ddc`

## Requirements
- R1: While `rst` is high, `out_vld`, `out_i` and `out_q` are 0 at the next rising edge. The phase count returns to 0, so the first accepted sample after reset gives I = +x and Q = 0.
- R2: Phases are numbered 0 to 3 and counted over accepted samples. The I lane applies the weights +1, 0, -1, 0 for phases 0, 1, 2 and 3.
- R3: When `spec_inv` = 0, the Q lane applies the weights 0, +1, 0, -1 for phases 0, 1, 2 and 3.
- R4: When `spec_inv` = 1, the Q lane weights become 0, -1, 0, +1. The I lane is unaffected.
- R5: A cycle with `in_vld` = 0 does not advance the phase, and `out_i` and `out_q` hold their values on the following cycle.
- R6: `out_vld` equals `in_vld` delayed by exactly one clock cycle.
- R7: Outputs are two's complement and one bit wider than the input. Negating the most negative input value gives its exact positive magnitude, and the value -2^DATA_W never appears.
- R8: A sample on a zero-weight phase still produces `out_vld` = 1 with a lane value of 0. On every valid output, at least one of the two lanes is 0.
- R9: A sampled fs/4 tone x[n] = c·cos(πn/2) − s·sin(πn/2), started at phase 0, gives I = c on even phases and Q = −s on odd phases (a constant phasor). The sign of Q is reversed when `spec_inv` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Marks a cycle that carries an input sample |
| in_smp | input | DATA_W | Input sample, two's complement |
| spec_inv | input | 1 | Negates the Q lane |
| out_vld | output | 1 | Marks a cycle that carries an output pair |
| out_i | output | DATA_W+1 | In-phase output, two's complement |
| out_q | output | DATA_W+1 | Quadrature output, two's complement |

## Verification
A phase count that slipped or advanced on an idle cycle would show on the very next valid output pair. The nonzero value would move to the wrong lane or take the wrong sign, and a tone would stop reading as a constant phasor. A wrong sign choice, or a missing extension bit, shows up as soon as the most negative sample hits a negating phase. The bench therefore compares every output cycle, idle cycles included, against a model built from the weight tables. It drives tones, gaps, the extreme value, both settings of the inversion control, and a reset in the middle of a stream.

// File: rtl/qddc_pkg.sv
package qddc_pkg;

   typedef logic [1:0] qddc_phase_t;

   typedef enum logic [1:0] {
      W_ZERO = 2'd0,
      W_POS  = 2'd1,
      W_NEG  = 2'd2
   } qddc_weight_e;

   // Lane weight for a phase, after the lane's lag in phases is removed.
   function automatic qddc_weight_e lane_weight(input qddc_phase_t ph,
                                                input qddc_phase_t lag,
                                                input logic        flip);
      qddc_phase_t rel;
      qddc_weight_e w;
      rel = ph - lag;
      case (rel)
         2'd0:    w = W_POS;
         2'd2:    w = W_NEG;
         default: w = W_ZERO;
      endcase
      if (flip && w == W_POS)      w = W_NEG;
      else if (flip && w == W_NEG) w = W_POS;
      return w;
   endfunction

endpackage

// File: rtl/qddc_phase_seq.sv
module qddc_phase_seq
   import qddc_pkg::*;
(
   input  logic        clk,
   input  logic        rst,
   input  logic        adv,
   output qddc_phase_t phase
);

   qddc_phase_t ph_q;

   always_ff @(posedge clk) begin
      if (rst)
         ph_q <= '0;
      else if (adv)
         ph_q <= ph_q + 2'd1;
   end

   assign phase = ph_q;

endmodule

// File: rtl/qddc_sign_lane.sv
module qddc_sign_lane
   import qddc_pkg::*;
#(
   parameter int DATA_W = 12,
   parameter int LAG    = 0
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                ld,
   input  qddc_phase_t         phase,
   input  logic                flip,
   input  logic [DATA_W-1:0]   smp,
   output logic [DATA_W:0]     res
);

   localparam int OUT_W = DATA_W + 1;
   localparam qddc_phase_t LAG_PH = qddc_phase_t'(LAG);

   qddc_weight_e      w;
   logic [OUT_W-1:0]  ext;
   logic [OUT_W-1:0]  nxt;
   logic [OUT_W-1:0]  res_q;

   always_comb begin
      w   = lane_weight(phase, LAG_PH, flip);
      ext = {smp[DATA_W-1], smp};
      case (w)
         W_POS:   nxt = ext;
         W_NEG:   nxt = (~ext) + OUT_W'(1);
         default: nxt = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst)
         res_q <= '0;
      else if (ld)
         res_q <= nxt;
   end

   assign res = res_q;

endmodule

// File: rtl/qrt_ddc.sv
module qrt_ddc
   import qddc_pkg::*;
#(
   parameter int DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_vld,
   input  logic [DATA_W-1:0] in_smp,
   input  logic              spec_inv,
   output logic              out_vld,
   output logic [DATA_W:0]   out_i,
   output logic [DATA_W:0]   out_q
);

   localparam int OUT_W  = DATA_W + 1;
   localparam int LANES  = 2;

   if (DATA_W < 2) begin : g_bad_width
      $error("qrt_ddc: DATA_W must be at least 2");
   end

   qddc_phase_t      phase;
   logic             vld_q;
   logic [OUT_W-1:0] lane_res [LANES];

   qddc_phase_seq u_seq (
      .clk   (clk),
      .rst   (rst),
      .adv   (in_vld),
      .phase (phase)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic flip;
      if (g == 0) begin : g_i
         assign flip = 1'b0;
      end else begin : g_q
         assign flip = spec_inv;
      end

      qddc_sign_lane #(
         .DATA_W (DATA_W),
         .LAG    (g)
      ) u_lane (
         .clk   (clk),
         .rst   (rst),
         .ld    (in_vld),
         .phase (phase),
         .flip  (flip),
         .smp   (in_smp),
         .res   (lane_res[g])
      );
   end

   always_ff @(posedge clk) begin
      if (rst)
         vld_q <= 1'b0;
      else
         vld_q <= in_vld;
   end

   assign out_vld = vld_q;
   assign out_i   = lane_res[0];
   assign out_q   = lane_res[1];

endmodule

// File: rtl/qddc_chk.sv
module qddc_chk #(
   parameter int DATA_W = 12
) (
   input logic              clk,
   input logic              rst,
   input logic              in_vld,
   input logic [DATA_W-1:0] in_smp,
   input logic              out_vld,
   input logic [DATA_W:0]   out_i,
   input logic [DATA_W:0]   out_q
);

   localparam logic [DATA_W:0] FORBIDDEN = {1'b1, {DATA_W{1'b0}}};

   // R1
   rst_clear_chk: assert property (@(posedge clk)
      rst |=> (!out_vld && out_i == '0 && out_q == '0));

   // R6
   vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
      in_vld |=> out_vld);

   // R6
   vld_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !in_vld |=> !out_vld);

   // R5
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !in_vld |=> ($stable(out_i) && $stable(out_q)));

   // R8
   one_lane_zero_chk: assert property (@(posedge clk) disable iff (rst)
      out_vld |-> (out_i == '0 || out_q == '0));

   // R2
   zero_in_zero_out_chk: assert property (@(posedge clk) disable iff (rst)
      (in_vld && in_smp == '0) |=> (out_i == '0 && out_q == '0));

   // R7
   no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
      out_vld |-> (out_i != FORBIDDEN && out_q != FORBIDDEN));

endmodule

bind qrt_ddc qddc_chk #(.DATA_W(DATA_W)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .in_vld  (in_vld),
   .in_smp  (in_smp),
   .out_vld (out_vld),
   .out_i   (out_i),
   .out_q   (out_q)
);

// File: tb/qrt_ddc_tb.sv
module qrt_ddc_tb;

   localparam int DW = 12;
   localparam int OW = DW + 1;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              in_vld = 1'b0;
   logic [DW-1:0]     in_smp = '0;
   logic              spec_inv = 1'b0;
   logic              out_vld;
   logic [OW-1:0]     out_i;
   logic [OW-1:0]     out_q;

   always #5 clk = ~clk;

   qrt_ddc #(.DATA_W(DW)) u_dut (
      .clk(clk), .rst(rst), .in_vld(in_vld), .in_smp(in_smp),
      .spec_inv(spec_inv), .out_vld(out_vld), .out_i(out_i), .out_q(out_q)
   );

   typedef struct {
      logic                 vld;
      logic signed [OW-1:0] i;
      logic signed [OW-1:0] q;
      string                tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_cmp  = 0;
   int   n_bad  = 0;
   bit   done   = 0;

   int                   m_ph = 0;
   logic signed [OW-1:0] m_i  = '0;
   logic signed [OW-1:0] m_q  = '0;

   // Monitor: away from the edge, compare the cycle captured at this edge.
   always @(posedge clk) begin
      #3;
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         n_cmp++;
         if (out_vld !== e.vld || $signed(out_i) !== e.i || $signed(out_q) !== e.q) begin
            n_bad++;
            $display("FAIL %s: vld/i/q got %0d/%0d/%0d expected %0d/%0d/%0d",
                     e.tag, out_vld, $signed(out_i), $signed(out_q), e.vld, e.i, e.q);
         end
      end
   end

   task automatic push(input logic v, input logic signed [OW-1:0] ei,
                       input logic signed [OW-1:0] eq, input string tag);
      exp_t e;
      e.vld = v; e.i = ei; e.q = eq; e.tag = tag;
      exp_q.push_back(e);
   endtask

   // Drive one sample; expected values from the weight tables of R2, R3, R4.
   task automatic send(input int x, input logic inv, input string tag);
      logic signed [OW-1:0] xe;
      @(negedge clk);
      in_vld = 1'b1; in_smp = DW'(x); spec_inv = inv;
      xe = OW'(x);
      case (m_ph)
         0: begin m_i = xe;  m_q = '0; end
         1: begin m_i = '0;  m_q = inv ? -xe : xe; end
         2: begin m_i = -xe; m_q = '0; end
         default: begin m_i = '0; m_q = inv ? xe : -xe; end
      endcase
      m_ph = (m_ph + 1) % 4;
      push(1'b1, m_i, m_q, tag);
   endtask

   task automatic idle(input int x, input string tag);
      @(negedge clk);
      in_vld = 1'b0; in_smp = DW'(x);
      push(1'b0, m_i, m_q, tag);
   endtask

   // fs/4 tone with DC expectation per R9.
   task automatic tone(input int c, input int s, input logic inv, input int n);
      for (int k = 0; k < n; k++) begin
         int x;
         logic signed [OW-1:0] ei, eq;
         case (m_ph)
            0: x = c;
            1: x = -s;
            2: x = -c;
            default: x = s;
         endcase
         ei = (m_ph % 2 == 0) ? OW'(c) : '0;
         eq = (m_ph % 2 == 1) ? (inv ? OW'(s) : OW'(-s)) : '0;
         @(negedge clk);
         in_vld = 1'b1; in_smp = DW'(x); spec_inv = inv;
         m_ph = (m_ph + 1) % 4;
         m_i = ei; m_q = eq;
         push(1'b1, ei, eq, inv ? "R9 R4 tone" : "R9 tone");
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; in_vld = 1'b0;
      @(posedge clk);
      #3;
      n_cmp++;
      if (out_vld !== 1'b0 || out_i !== '0 || out_q !== '0) begin
         n_bad++;
         $display("FAIL R1 reset: vld/i/q got %0d/%0d/%0d expected 0/0/0",
                  out_vld, $signed(out_i), $signed(out_q));
      end
      @(negedge clk);
      rst = 1'b0;
      m_ph = 0; m_i = '0; m_q = '0;
   endtask

   initial begin
      logic [15:0] lfsr = 16'hACE1;
      do_reset();

      // R9, R2, R8: cosine tone, then tone with both components
      tone(900, 0, 1'b0, 8);
      tone(500, 300, 1'b0, 8);
      // R3: sine-only tone gives constant Q
      tone(0, -700, 1'b0, 8);
      // R4: inverted orientation
      tone(400, 250, 1'b1, 8);
      send(123, 1'b1, "R4 inv I phase0");
      send(77, 1'b1, "R4 inv Q phase1");

      // R5, R6: gaps do not advance the phase and outputs hold
      idle(555, "R5 idle hold");
      idle(-3, "R5 idle hold");
      send(10, 1'b0, "R5 after gap");
      idle(99, "R6 vld drop");
      send(20, 1'b0, "R5 after gap");
      send(30, 1'b0, "R8 zero lane");
      idle(0, "R6 vld drop");
      send(40, 1'b0, "R2 phase0");

      // R7: most negative value through negating phases
      do_reset();
      send(-2048, 1'b0, "R7 phase0");
      send(-2048, 1'b0, "R7 phase1");
      send(-2048, 1'b0, "R7 phase2 negate");
      send(-2048, 1'b0, "R7 phase3 negate");
      send(-2048, 1'b1, "R7 R4 phase0");
      send(-2048, 1'b1, "R7 R4 phase1 negate");

      // R1: reset in mid-stream restarts at phase 0
      send(11, 1'b0, "R2 pre-reset");
      do_reset();
      send(321, 1'b0, "R1 first after reset");
      send(321, 1'b0, "R1 second after reset");

      // R2, R3: pseudo-random samples with occasional gaps
      for (int k = 0; k < 64; k++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (lfsr[3:0] == 4'h0) idle(int'($signed(lfsr[11:0])), "R5 random gap");
         else send(int'($signed(lfsr[11:0])), lfsr[7], "R2 R3 random");
      end
      idle(0, "R6 tail");
      repeat (3) @(negedge clk);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish, got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule